// File: doc/BRIEF.md
# Flash Identification and Boot-Lock Command Controller

This block is the command interface of a 512K x 8 parallel NOR flash model. It watches the asynchronous bus controls (chip enable, output enable and write enable, all active low) against a local clock. It turns each rising edge of the write strobe into one bus-write event. A small sequencer checks these events against the multi-cycle unlock protocol. Once a sequence is complete, the block enters or leaves identification mode, stores a boot-block lockout setting, or decides whether a program or erase request may proceed.

In identification mode a read returns one of three values: the manufacturer byte, the device byte, or the lock status of the bottom or top boot block. Each identifier byte has odd parity, with the top data bit as the parity bit. In normal mode reads return the erased pattern 0xFF, because the array itself lies outside the block. Program and erase requests produce a one-cycle permit pulse only when the target lies outside the locked range. The lockout setting can be written once and stays until reset.

Top module: `flash_boot_ctl`

## Requirements
- R1: After reset the block is in normal mode with no lockout. A normal-mode read with ce_n and oe_n low returns 0xFF, and pe_permit is low.
- R2: A bus write is taken at the clock edge that first sees we_n high after a cycle with we_n low, while ce_n is low and oe_n is high. A strobe given while oe_n is low or ce_n is high is not taken.
- R3: The writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0x90 to 0x5555 enter identification mode. There a read with address bit 1 low returns 0xDA when address bit 0 is 0 and 0xB6 when it is 1. Both bytes have an odd number of ones.
- R4: Identification mode is left by the unlock pair followed by 0xF0 to 0x5555, or by a single 0xF0 written to any address outside a pending operand.
- R5: A write that breaks an unlock sequence (wrong address or data) aborts it, and the sequence has no effect.
- R6: The unlock pair, then 0x40 to 0x5555, then one configuration write sets the lockout. Data bit 1 selects the location (1 = top, 0 = bottom) and data bit 0 the size (1 = 64K, 0 = 16K). Once set, a later lockout command does not change it.
- R7: In identification mode, address 0x00002 reports the bottom block and 0x7FFF2 the top block. Data bit 1 is 1 when that block is locked, data bit 0 is 1 when it is locked at 64K, and all other bits are 0.
- R8: The unlock pair, then 0xA0 to 0x5555, then one write to a target requests a program. pe_permit is high for exactly the one cycle after the target write is taken, and only if the target is not locked.
- R9: The unlock pair, 0x80 to 0x5555, the unlock pair again, then 0x30 to a target requests an erase, with the same permit rule as R8.
- R10: The locked ranges are 0x00000-0x03FFF (bottom 16K), 0x00000-0x0FFFF (bottom 64K), 0x7C000-0x7FFFF (top 16K) and 0x70000-0x7FFFF (top 64K).
- R11: While ce_n or oe_n is high, rd_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock that samples the bus controls |
| rst_n | input | 1 | Active-low reset, returns to normal mode and clears lockout |
| addr | input | 19 | Bus address |
| din | input | 8 | Bus write data |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low, taken on its rising edge |
| rd_data | output | 8 | Read data |
| pe_permit | output | 1 | One-cycle pulse granting a program or erase |

## Verification
The hardest situations to reach are the ones that depend on the one-time lockout. Only one configuration can exist per reset, and any attempt to overwrite it must leave every boundary address unchanged. The stimulus therefore resets between phases, sets each of the four configurations in turn, and in each phase requests programs on both sides of the range edge. In the bottom-16K phase it also issues a second lockout command that would select 64K, then shows that the status read and a program just above 16K are unchanged. Aborted sequences are produced by an unlock whose middle write has a wrong address, by strobes given with oe_n low or ce_n high, and by an erase whose second unlock pair is misaddressed.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_U1,
        ST_U2,
        ST_PROG,
        ST_E1,
        ST_E2,
        ST_E3,
        ST_LOCK
    } seq_state_e;

    typedef struct packed {
        logic set;
        logic top;
        logic big;
    } lock_cfg_t;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] OP_ID_ON    = 8'h90;
    localparam logic [7:0] OP_RESET    = 8'hF0;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] OP_ERASE_GO = 8'h30;
    localparam logic [7:0] OP_LOCK     = 8'h40;

endpackage

// File: rtl/fbc_bus_capture.sv
module fbc_bus_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_evt
);
    typedef struct packed {
        logic we_prev;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d         = cap_q;
        cap_d.we_prev = we_n;
        wr_evt        = !cap_q.we_prev && we_n && !ce_n && oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '{we_prev: 1'b1};
        else        cap_q <= cap_d;
    end
endmodule

// File: rtl/fbc_lock_range.sv
module fbc_lock_range
    import fbc_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int SMALL_W = 14,
    parameter int LARGE_W = 16
) (
    input  lock_cfg_t          cfg,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit
);
    logic [1:0] bot_m;
    logic [1:0] top_m;

    for (genvar gi = 0; gi < 2; gi++) begin : g_size
        localparam int BW = (gi == 1) ? LARGE_W : SMALL_W;
        assign bot_m[gi] = ~|addr[ADDR_W-1:BW];
        assign top_m[gi] =  &addr[ADDR_W-1:BW];
    end

    always_comb begin
        hit = cfg.set && (cfg.top ? top_m[cfg.big] : bot_m[cfg.big]);
    end
endmodule

// File: rtl/fbc_sequencer.sv
module fbc_sequencer
    import fbc_pkg::*;
#(
    parameter int               ADDR_W = 19,
    parameter int               DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_A1 = 19'h05555,
    parameter logic [ADDR_W-1:0] KEY_A2 = 19'h02AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tgt_hit,
    output logic              id_mode,
    output lock_cfg_t         lock_cfg,
    output logic              pe_permit
);
    typedef struct packed {
        seq_state_e st;
        logic       id;
        lock_cfg_t  lock;
        logic       permit;
    } seq_t;

    seq_t s_d, s_q;

    logic at_a1, at_a2;
    logic operand;

    always_comb begin
        at_a1   = (wr_addr == KEY_A1);
        at_a2   = (wr_addr == KEY_A2);
        operand = (s_q.st == ST_PROG) || (s_q.st == ST_LOCK);

        s_d        = s_q;
        s_d.permit = 1'b0;

        if (wr_evt) begin
            s_d.st = ST_IDLE;
            unique case (s_q.st)
                ST_IDLE: begin
                    if (at_a1 && wr_data == DATA_W'(KEY_FIRST)) s_d.st = ST_U1;
                end
                ST_U1: begin
                    if (at_a2 && wr_data == DATA_W'(KEY_SECOND)) s_d.st = ST_U2;
                end
                ST_U2: begin
                    if (at_a1) begin
                        if (wr_data == DATA_W'(OP_ID_ON))   s_d.id = 1'b1;
                        if (wr_data == DATA_W'(OP_PROGRAM)) s_d.st = ST_PROG;
                        if (wr_data == DATA_W'(OP_ERASE))   s_d.st = ST_E1;
                        if (wr_data == DATA_W'(OP_LOCK))    s_d.st = ST_LOCK;
                    end
                end
                ST_PROG: begin
                    s_d.permit = !tgt_hit;
                end
                ST_E1: begin
                    if (at_a1 && wr_data == DATA_W'(KEY_FIRST)) s_d.st = ST_E2;
                end
                ST_E2: begin
                    if (at_a2 && wr_data == DATA_W'(KEY_SECOND)) s_d.st = ST_E3;
                end
                ST_E3: begin
                    if (wr_data == DATA_W'(OP_ERASE_GO)) s_d.permit = !tgt_hit;
                end
                ST_LOCK: begin
                    if (!s_q.lock.set) begin
                        s_d.lock.set = 1'b1;
                        s_d.lock.top = wr_data[1];
                        s_d.lock.big = wr_data[0];
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase

            if (!operand && wr_data == DATA_W'(OP_RESET)) begin
                s_d.st     = ST_IDLE;
                s_d.id     = 1'b0;
                s_d.permit = 1'b0;
            end
        end

        id_mode   = s_q.id;
        lock_cfg  = s_q.lock;
        pe_permit = s_q.permit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.id     <= 1'b0;
            s_q.lock   <= '0;
            s_q.permit <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/fbc_id_mux.sv
module fbc_id_mux
    import fbc_pkg::*;
#(
    parameter int               ADDR_W   = 19,
    parameter int               DATA_W   = 8,
    parameter logic [DATA_W-1:0] MFR_CODE = 8'hDA,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'hB6
) (
    input  logic              id_mode,
    input  lock_cfg_t         lock_cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] BOT_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] TOP_STAT = {{(ADDR_W-4){1'b1}}, 4'h2};

    logic              here;
    logic [DATA_W-1:0] status;

    always_comb begin
        here = 1'b0;
        if (addr == BOT_STAT) here = lock_cfg.set && !lock_cfg.top;
        if (addr == TOP_STAT) here = lock_cfg.set &&  lock_cfg.top;

        status    = '0;
        status[1] = here;
        status[0] = here && lock_cfg.big;

        if (ce_n || oe_n)  rd_data = '0;
        else if (!id_mode) rd_data = '1;
        else if (!addr[1]) rd_data = addr[0] ? DEV_CODE : MFR_CODE;
        else               rd_data = status;
    end
endmodule

// File: rtl/flash_boot_ctl.sv
module flash_boot_ctl
    import fbc_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int SMALL_W = 14,
    parameter int LARGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              pe_permit
);
    logic      wr_evt;
    logic      tgt_hit;
    logic      id_mode;
    lock_cfg_t lock_cfg;

    fbc_bus_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .wr_evt (wr_evt)
    );

    fbc_lock_range #(
        .ADDR_W  (ADDR_W),
        .SMALL_W (SMALL_W),
        .LARGE_W (LARGE_W)
    ) u_range (
        .cfg  (lock_cfg),
        .addr (addr),
        .hit  (tgt_hit)
    );

    fbc_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (wr_evt),
        .wr_addr   (addr),
        .wr_data   (din),
        .tgt_hit   (tgt_hit),
        .id_mode   (id_mode),
        .lock_cfg  (lock_cfg),
        .pe_permit (pe_permit)
    );

    fbc_id_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .id_mode  (id_mode),
        .lock_cfg (lock_cfg),
        .addr     (addr),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/fbc_chk.sv
module fbc_chk
    import fbc_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              pe_permit,
    input logic              wr_evt,
    input logic              id_mode,
    input lock_cfg_t         lock_cfg
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pe_permit |=> !pe_permit);

    a_r8_permit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        pe_permit |-> $past(wr_evt));

    a_r2_no_write_when_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !wr_evt);

    a_r3_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && !ce_n && !oe_n && !addr[1]) |-> ($countones(rd_data) % 2 == 1));

    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_cfg.set |=> (lock_cfg.set && $stable(lock_cfg)));

    a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (rd_data == '0));
endmodule

bind flash_boot_ctl fbc_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .rd_data   (rd_data),
    .pe_permit (pe_permit),
    .wr_evt    (wr_evt),
    .id_mode   (id_mode),
    .lock_cfg  (lock_cfg)
);

// File: tb/flash_boot_ctl_test.sv
module flash_boot_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  din = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [7:0]  rd_data;
    logic        pe_permit;

    int n_checks = 0;
    int n_fails  = 0;
    bit    exp_q[$];
    string tag_q[$];
    event  samp_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_boot_ctl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rd_data(rd_data), .pe_permit(pe_permit)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected permit values as requests complete
    initial forever begin
        @(samp_ev);
        if (exp_q.size() == 0) begin
            check("scoreboard underflow", 8'h1, 8'h0);
        end else begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {7'b0, pe_permit}, {7'b0, e});
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [18:0] a, input logic [7:0] d,
                          input logic ce = 1'b0, input logic oe = 1'b1);
        addr = a; din = d; ce_n = ce; oe_n = oe; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    // final write of a request: pushes the expected permit and samples it
    task automatic req_wr(input logic [18:0] a, input logic [7:0] d,
                          input bit exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        -> samp_ev;
        #1;
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [18:0] a, input logic [7:0] exp, input string tag);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        check(tag, rd_data, exp);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        bus_wr(19'h05555, 8'hAA);
        bus_wr(19'h02AAA, 8'h55);
    endtask

    task automatic id_on();
        unlock(); bus_wr(19'h05555, 8'h90);
    endtask

    task automatic set_lock(input logic [7:0] cfg);
        unlock(); bus_wr(19'h05555, 8'h40); bus_wr(19'h00000, cfg);
    endtask

    task automatic prog(input logic [18:0] a, input bit exp, input string tag);
        unlock(); bus_wr(19'h05555, 8'hA0); req_wr(a, 8'h3C, exp, tag);
    endtask

    task automatic erase(input logic [18:0] a, input bit exp, input string tag);
        unlock(); bus_wr(19'h05555, 8'h80); unlock();
        req_wr(a, 8'h30, exp, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state, R11 idle bus
        check("R1 permit low after reset", {7'b0, pe_permit}, 8'h00);
        check("R11 idle bus output", rd_data, 8'h00);
        rd(19'h00000, 8'hFF, "R1 normal read");

        // R3 identification codes
        id_on();
        rd(19'h00000, 8'hDA, "R3 manufacturer code");
        rd(19'h00001, 8'hB6, "R3 device code");
        rd(19'h12340, 8'hDA, "R3 code with A1 low elsewhere");
        rd(19'h00002, 8'h00, "R7 bottom unlocked");
        rd(19'h7FFF2, 8'h00, "R7 top unlocked");
        addr = 19'h00000; ce_n = 1'b0; oe_n = 1'b1; #1;
        check("R11 oe high in id mode", rd_data, 8'h00);
        ce_n = 1'b1; @(negedge clk);

        // R4 exits
        unlock(); bus_wr(19'h05555, 8'hF0);
        rd(19'h00000, 8'hFF, "R4 three-cycle exit");
        id_on();
        bus_wr(19'h01234, 8'hF0);
        rd(19'h00000, 8'hFF, "R4 single-cycle exit");

        // R5 broken sequence
        bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAB, 8'h55); bus_wr(19'h05555, 8'h90);
        rd(19'h00000, 8'hFF, "R5 wrong address aborts");

        // R2 strobes not taken
        bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAA, 8'h55, 1'b0, 1'b0);
        bus_wr(19'h05555, 8'h90);
        rd(19'h00000, 8'hFF, "R2 write with oe low ignored");
        bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAA, 8'h55, 1'b1, 1'b1);
        bus_wr(19'h05555, 8'h90);
        rd(19'h00000, 8'hFF, "R2 write with ce high ignored");

        // R8 unlocked program
        prog(19'h00000, 1'b1, "R8 program unlocked array");

        // bottom 16K lock
        set_lock(8'h00);
        prog(19'h03FFF, 1'b0, "R10 bottom16 last locked");
        prog(19'h04000, 1'b1, "R10 bottom16 first free");
        erase(19'h00000, 1'b0, "R9 erase locked refused");
        erase(19'h7FFFF, 1'b1, "R9 erase free granted");
        unlock(); bus_wr(19'h05555, 8'h80);
        bus_wr(19'h05554, 8'hAA); bus_wr(19'h02AAA, 8'h55);
        req_wr(19'h40000, 8'h30, 1'b0, "R5 broken erase no permit");
        set_lock(8'h03);
        prog(19'h04000, 1'b1, "R6 second lock ignored");
        id_on();
        rd(19'h00002, 8'h02, "R7 bottom 16K status");
        rd(19'h7FFF2, 8'h00, "R7 top not locked");
        bus_wr(19'h00000, 8'hF0);

        // top 64K
        do_reset();
        set_lock(8'h03);
        prog(19'h70000, 1'b0, "R10 top64 first locked");
        prog(19'h6FFFF, 1'b1, "R10 top64 below free");
        id_on();
        rd(19'h7FFF2, 8'h03, "R7 top 64K status");
        rd(19'h00002, 8'h00, "R7 bottom not locked");
        bus_wr(19'h00000, 8'hF0);

        // top 16K
        do_reset();
        rd(19'h00000, 8'hFF, "R1 reset clears id and lock");
        set_lock(8'h02);
        prog(19'h7BFFF, 1'b1, "R10 top16 below free");
        prog(19'h7C000, 1'b0, "R10 top16 first locked");
        id_on();
        rd(19'h7FFF2, 8'h02, "R7 top 16K status");
        bus_wr(19'h00000, 8'hF0);

        // bottom 64K
        do_reset();
        set_lock(8'h01);
        prog(19'h0FFFF, 1'b0, "R10 bottom64 last locked");
        prog(19'h10000, 1'b1, "R10 bottom64 first free");
        erase(19'h08000, 1'b0, "R9 erase inside bottom64 refused");
        id_on();
        rd(19'h00002, 8'h03, "R7 bottom 64K status");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("scoreboard leftover", 8'(exp_q.size()), 8'h00);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule